// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block collects up to 32 interrupt request lines into a single interrupt output for a processor. Every request line is first brought into the controller's clock domain. Each line is then watched as an edge or as a level, and software picks the active sense for each line separately. A detected event sets a pending bit, which stays set until software writes a one to that bit. Per-source enable bits decide which pending bits drive the combined interrupt line.

Software uses a simple register port with valid, write, address and data. The port reads and writes the enable, pending, detection-mode, active-sense, output-style, output-sense and software-inject registers. The output line can be a steady level or a single-cycle pulse, and either form can be inverted. The software-inject register lets code raise any pending bit without a hardware event, which helps with testing and with inter-task signalling.

Top module: `irqc_top`

## Requirements
- R1: While reset is held, every register reads 0 and `irq_out` is 0.
- R2: A source with its mode bit at 1 (edge) sets its pending bit on a rising input change when its sense bit is 1, and on a falling change when its sense bit is 0. The pending bit becomes visible in the third clock after the input changes, after two synchroniser stages and one detection stage. The opposite transition has no effect.
- R3: A source with its mode bit at 0 (level) sets its pending bit while its synchronised input equals its sense bit. While that input stays asserted, a write-one-to-clear leaves the bit set. Once the input is released, the bit stays latched until software clears it.
- R4: Writing the status register (offset 0x04) clears each pending bit written as 1 and leaves each bit written as 0 unchanged.
- R5: If a hardware event and a clearing write hit the same pending bit on the same clock edge, the bit stays set.
- R6: Writing a 1 to a bit of the inject register (offset 0x18) sets that pending bit on the write edge. The inject register always reads 0.
- R7: Pending bits whose enable bit (offset 0x00) is 0 never drive `irq_out` active.
- R8: With output style 0 (offset 0x10, bit 0), the output goes active one clock after an enabled pending bit appears and stays active while any enabled pending bit remains.
- R9: With output style 1, the output is active for exactly one clock when the enabled-pending set changes from empty to non-empty. Further pending bits arriving while the set is non-empty give no new pulse.
- R10: An output-sense bit of 0 (offset 0x14, bit 0) gives an active-high `irq_out`. A value of 1 inverts the line immediately after the write.
- R11: After a source's mode or sense changes, clearing its pending bit discards the stale event, and the bit stays clear while the input holds steady.
- R12: The registers sit at these offsets: enable 0x00, status 0x04, mode 0x08, sense 0x0C, output style 0x10, output sense 0x14, inject 0x18. Registers read back as written, the output style and sense registers read back only bit 0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32 | Raw interrupt request lines, asynchronous |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The pending-bit properties assume that the register port presents at most one access per cycle and that a write lasts exactly one clock. The bench's write task guarantees this by raising valid for a single edge and then dropping it. The output pulse property assumes that output style changes only through single writes, and the stimulus changes it only while no enabled bit is pending. All stimulus, including the raw request lines, changes one time unit after a rising edge. This keeps the three-stage latency from input change to pending bit exact, so the bench can place the collision of an edge and a clearing write on a known edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Byte offsets of the register file
  localparam int OFS_ENABLE   = 'h00;
  localparam int OFS_STATUS   = 'h04;
  localparam int OFS_MODE     = 'h08;
  localparam int OFS_SENSE    = 'h0C;
  localparam int OFS_OUT_MODE = 'h10;
  localparam int OFS_OUT_POL  = 'h14;
  localparam int OFS_INJECT   = 'h18;

  // Input is asserted when it matches the selected sense
  function automatic logic qualify(input logic raw, input logic sense);
    return raw ~^ sense;
  endfunction

  // Event for one source: asserted transition in edge mode, asserted level otherwise
  function automatic logic src_hit(input logic edge_mode, input logic sense,
                                   input logic now, input logic prev);
    logic q_now, q_prev;
    q_now  = qualify(now, sense);
    q_prev = qualify(prev, sense);
    return edge_mode ? (q_now & ~q_prev) : q_now;
  endfunction

  // Pending update: a new event dominates a clear request
  function automatic logic next_pending(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] now_q,
  output logic [W-1:0] prev_q
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= din;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign now_q  = pipe[STAGES-1];
  assign prev_q = pipe[STAGES];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
  import irqc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] smp_now,
  input  logic [NSRC-1:0] smp_prev,
  input  logic [NSRC-1:0] src_mode,
  input  logic [NSRC-1:0] src_sense,
  input  logic [NSRC-1:0] clr_mask,
  input  logic [NSRC-1:0] inject_mask,
  output logic [NSRC-1:0] set_mask,
  output logic [NSRC-1:0] status_q
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign set_mask[i] = src_hit(src_mode[i], src_sense[i], smp_now[i], smp_prev[i])
                         | inject_mask[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= next_pending(status_q[i], clr_mask[i], set_mask[i]);
    end
  end

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_mask)) |=> ((status_q & $past(clr_mask & ~set_mask)) == '0));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((~status_q & $past(set_mask)) == '0));

endmodule

// File: rtl/irqc_out.sv
module irqc_out (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_any,
  input  logic out_mode,
  input  logic out_pol,
  output logic irq_out
);
  logic pend_q;
  logic active_q;
  logic rise;

  assign rise = pend_any & ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      pend_q   <= pend_any;
      active_q <= out_mode ? rise : pend_any;
    end
  end

  assign irq_out = active_q ^ out_pol;

  // R9
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode && active_q) |=> (!active_q || !out_mode));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_any) |=> !active_q);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int SYNC_ST = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_out
);
  localparam logic [AW-1:0] A_ENABLE   = AW'(OFS_ENABLE);
  localparam logic [AW-1:0] A_STATUS   = AW'(OFS_STATUS);
  localparam logic [AW-1:0] A_MODE     = AW'(OFS_MODE);
  localparam logic [AW-1:0] A_SENSE    = AW'(OFS_SENSE);
  localparam logic [AW-1:0] A_OUT_MODE = AW'(OFS_OUT_MODE);
  localparam logic [AW-1:0] A_OUT_POL  = AW'(OFS_OUT_POL);
  localparam logic [AW-1:0] A_INJECT   = AW'(OFS_INJECT);

  logic [NSRC-1:0] enable_q, mode_q, sense_q;
  logic            out_mode_q, out_pol_q;
  logic [NSRC-1:0] smp_now, smp_prev;
  logic [NSRC-1:0] clr_mask, inject_mask, set_mask, status_q;
  logic            wr;

  assign wr = bus_valid & bus_write;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q   <= '0;
      mode_q     <= '0;
      sense_q    <= '0;
      out_mode_q <= 1'b0;
      out_pol_q  <= 1'b0;
    end else if (wr) begin
      if (bus_addr == A_ENABLE)   enable_q   <= bus_wdata[NSRC-1:0];
      if (bus_addr == A_MODE)     mode_q     <= bus_wdata[NSRC-1:0];
      if (bus_addr == A_SENSE)    sense_q    <= bus_wdata[NSRC-1:0];
      if (bus_addr == A_OUT_MODE) out_mode_q <= bus_wdata[0];
      if (bus_addr == A_OUT_POL)  out_pol_q  <= bus_wdata[0];
    end
  end

  assign clr_mask    = (wr && bus_addr == A_STATUS) ? bus_wdata[NSRC-1:0] : '0;
  assign inject_mask = (wr && bus_addr == A_INJECT) ? bus_wdata[NSRC-1:0] : '0;

  // Read path, same cycle
  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        A_ENABLE:   bus_rdata = DW'(enable_q);
        A_STATUS:   bus_rdata = DW'(status_q);
        A_MODE:     bus_rdata = DW'(mode_q);
        A_SENSE:    bus_rdata = DW'(sense_q);
        A_OUT_MODE: bus_rdata = DW'(out_mode_q);
        A_OUT_POL:  bus_rdata = DW'(out_pol_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  irqc_sync #(.W(NSRC), .STAGES(SYNC_ST)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (src_in),
    .now_q  (smp_now),
    .prev_q (smp_prev)
  );

  irqc_detect #(.NSRC(NSRC)) u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_now     (smp_now),
    .smp_prev    (smp_prev),
    .src_mode    (mode_q),
    .src_sense   (sense_q),
    .clr_mask    (clr_mask),
    .inject_mask (inject_mask),
    .set_mask    (set_mask),
    .status_q    (status_q)
  );

  irqc_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_any (|(status_q & enable_q)),
    .out_mode (out_mode_q),
    .out_pol  (out_pol_q),
    .irq_out  (irq_out)
  );

  // R6
  inject_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == A_INJECT) |-> (bus_rdata == '0));

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_in;
  logic        bus_valid, bus_write;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int vectors = 0;
  int fails   = 0;

  localparam logic [4:0] R_EN = 5'h00, R_ST = 5'h04, R_MD = 5'h08, R_SN = 5'h0C,
                         R_OM = 5'h10, R_OP = 5'h14, R_FI = 5'h18, R_NONE = 5'h1C;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset();
    tick(2);
    expect_reg("R1 enable in reset", R_EN, 32'h0);
    expect_reg("R1 status in reset", R_ST, 32'h0);
    expect_reg("R1 mode in reset", R_MD, 32'h0);
    expect_reg("R1 sense in reset", R_SN, 32'h0);
    expect_reg("R1 out style in reset", R_OM, 32'h0);
    check("R1 irq_out in reset", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic t_regmap();
    wr(R_EN, 32'hA5A5_5A5A); expect_reg("R12 enable readback", R_EN, 32'hA5A5_5A5A);
    wr(R_MD, 32'h0F0F_1234); expect_reg("R12 mode readback", R_MD, 32'h0F0F_1234);
    wr(R_SN, 32'hCAFE_0001); expect_reg("R12 sense readback", R_SN, 32'hCAFE_0001);
    wr(R_OM, 32'hFFFF_FFFF); expect_reg("R12 out style bit0 only", R_OM, 32'h1);
    wr(R_OP, 32'hFFFF_FFFE); expect_reg("R12 out sense bit0 only", R_OP, 32'h0);
    expect_reg("R6 inject reads zero", R_FI, 32'h0);
    expect_reg("R12 unmapped reads zero", R_NONE, 32'h0);
    wr(R_EN, 32'h0); wr(R_OM, 32'h0); wr(R_OP, 32'h0);
    wr(R_MD, 32'h0); wr(R_SN, 32'hFFFF_FFFF);
    tick(3);
    wr(R_ST, 32'hFFFF_FFFF);
    tick(3);
    expect_reg("R4 all cleared after setup", R_ST, 32'h0);
  endtask

  task automatic t_edge();
    wr(R_MD, 32'h0000_0003);
    wr(R_SN, 32'hFFFF_FFFD);
    wr(R_ST, 32'hFFFF_FFFF);
    src_in = 32'h3;
    tick(2);
    expect_reg("R2 not yet after two stages", R_ST, 32'h0);
    tick(1);
    expect_reg("R2 rising edge on bit0 only", R_ST, 32'h1);
    tick(3);
    expect_reg("R2 rising ignored on falling source", R_ST, 32'h1);
    wr(R_ST, 32'h1);
    expect_reg("R4 edge bit cleared", R_ST, 32'h0);
    src_in = 32'h0;
    tick(2);
    expect_reg("R2 falling not yet", R_ST, 32'h0);
    tick(1);
    expect_reg("R2 falling edge on bit1 only", R_ST, 32'h2);
    wr(R_ST, 32'hFFFF_FFFF);
  endtask

  task automatic t_w1c();
    wr(R_FI, 32'h0000_00F0);
    expect_reg("R6 inject sets on write edge", R_ST, 32'hF0);
    wr(R_ST, 32'h0000_0030);
    expect_reg("R4 ones clear, zeros keep", R_ST, 32'hC0);
    wr(R_ST, 32'h0000_00C0);
    expect_reg("R4 remaining cleared", R_ST, 32'h0);
  endtask

  task automatic t_level();
    src_in = 32'h4;
    tick(2);
    expect_reg("R3 level not yet", R_ST, 32'h0);
    tick(1);
    expect_reg("R3 level high sets", R_ST, 32'h4);
    wr(R_ST, 32'h4);
    expect_reg("R3 clear has no effect while held", R_ST, 32'h4);
    src_in = 32'h0;
    tick(4);
    expect_reg("R3 stays latched after release", R_ST, 32'h4);
    wr(R_ST, 32'h4);
    tick(3);
    expect_reg("R3 clears after release", R_ST, 32'h0);
    wr(R_SN, 32'hFFFF_FFF5);
    tick(1);
    expect_reg("R3 active-low level with input low", R_ST, 32'h8);
    wr(R_SN, 32'hFFFF_FFFD);
    tick(1);
    wr(R_ST, 32'hFFFF_FFFF);
    expect_reg("R3 active-low cleared after sense restore", R_ST, 32'h0);
  endtask

  task automatic t_collide();
    wr(R_FI, 32'h21);
    src_in = 32'h1;
    tick(2);
    wr(R_ST, 32'h21);
    expect_reg("R5 edge beats clear, other bit cleared", R_ST, 32'h1);
    wr(R_ST, 32'h1);
    tick(2);
    expect_reg("R5 plain clear afterwards", R_ST, 32'h0);
  endtask

  task automatic t_stale();
    src_in = 32'h41;
    tick(3);
    expect_reg("R11 level pending before change", R_ST, 32'h40);
    wr(R_MD, 32'h43);
    wr(R_ST, 32'h40);
    tick(4);
    expect_reg("R11 stale event discarded", R_ST, 32'h0);
  endtask

  task automatic t_out_level();
    wr(R_ST, 32'hFFFF_FFFF);
    wr(R_FI, 32'h10);
    tick(3);
    check("R7 masked pending keeps line idle", {31'h0, irq_out}, 32'h0);
    wr(R_EN, 32'h10);
    check("R8 not active on enable edge", {31'h0, irq_out}, 32'h0);
    tick(1);
    check("R8 active one clock later", {31'h0, irq_out}, 32'h1);
    tick(5);
    check("R8 stays active", {31'h0, irq_out}, 32'h1);
    wr(R_OP, 32'h1);
    check("R10 inverted immediately", {31'h0, irq_out}, 32'h0);
    wr(R_ST, 32'h10);
    check("R10 still active (low) on clear edge", {31'h0, irq_out}, 32'h0);
    tick(1);
    check("R10 inverted idle is high", {31'h0, irq_out}, 32'h1);
    wr(R_OP, 32'h0);
    check("R10 idle high-active line low", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic t_out_pulse();
    wr(R_OM, 32'h1);
    wr(R_FI, 32'h10);
    check("R9 no pulse on inject edge", {31'h0, irq_out}, 32'h0);
    tick(1);
    check("R9 pulse high", {31'h0, irq_out}, 32'h1);
    tick(1);
    check("R9 pulse one clock only", {31'h0, irq_out}, 32'h0);
    wr(R_EN, 32'h30);
    wr(R_FI, 32'h20);
    tick(1);
    check("R9 no pulse while set non-empty", {31'h0, irq_out}, 32'h0);
    tick(1);
    check("R9 still quiet", {31'h0, irq_out}, 32'h0);
    wr(R_ST, 32'hFFFF_FFFF);
    tick(2);
    wr(R_FI, 32'h20);
    tick(1);
    check("R9 new pulse after set emptied", {31'h0, irq_out}, 32'h1);
    tick(1);
    check("R9 second pulse ends", {31'h0, irq_out}, 32'h0);
    wr(R_ST, 32'hFFFF_FFFF);
    wr(R_OM, 32'h0);
    wr(R_EN, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; src_in = '0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_regmap();
    t_edge();
    t_w1c();
    t_level();
    t_collide();
    t_stale();
    t_out_level();
    t_out_pulse();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule